// File: doc/BRIEF.md
# SPI Flash Command Shift Engine

This block runs one short command on a serial NOR flash through a register-loaded shift engine. Software writes up to six outgoing bytes and a bit count, chooses the SCK half-period, and then pulses `start`. The engine pulls chip select low and clocks the programmed number of bits in SPI mode 0. The opcode byte goes out first, MSB first, and the remaining bytes follow it. At the same time every bit seen on MISO is shifted into a seven-byte receive bank, which software reads once `done` pulses.

A single bit counter governs both directions. The transmit side therefore carries one opcode plus at most five further bytes. The receive side holds up to seven bytes. The first of these was clocked in while the opcode was being sent and carries no data, so software discards it. The newest received byte always sits at read index 0.

Top module: `spi_cmd_engine`

## Requirements
- R1: Write address 6 holds the bit count N. A written value above 56 is stored as 56. A command with N > 0 produces exactly N rising SCK edges while CS_n is low.
- R2: Write addresses 0..5 hold transmit bytes T0..T5. MOSI carries T5 (the opcode) first, then T4 down to T0, each MSB first. Bits past the 48th are driven as 0.
- R3: The receive bank is cleared when a command with N > 0 starts, and one MISO bit is shifted in at each rising SCK edge. Afterwards, read index i (`rd_addr` 0..6) returns bits 8i+7..8i of the received stream, right-justified, so the last bit received is bit 0 of index 0.
- R4: A `start` pulse while busy is ignored and does not lengthen or restart the running command.
- R5: SCK is low whenever CS_n is high. CS_n falls H system cycles before the first rising SCK edge and rises H cycles after the last falling edge. CS_n is low for (2N+1)·H cycles in total.
- R6: SPI mode 0: MOSI changes only when SCK falls or when CS_n falls, never while SCK is high.
- R7: Write address 7 holds the half-period H in system clocks. A value of 0 acts as 1, and each SCK level lasts H cycles.
- R8: After reset, `busy` and `done` are low, CS_n is high and SCK is low. `busy` is high from the edge that accepts `start` until the edge that raises CS_n. `done` is high for exactly one cycle, on that same edge.
- R9: With N = 0, `start` toggles no SCK, leaves CS_n high and `busy` low, and pulses `done` for one cycle on the next edge.
- R10: Writes to any address while `busy` is high are ignored. A later command started without rewriting the registers uses the old count, bytes and half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0..5 transmit bytes, 6 bit count, 7 half-period |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Receive bank byte index |
| rd_data | output | 8 | Receive bank byte at `rd_addr` |
| start | input | 1 | Execute strobe |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Every bit count from 0 to 56 is run once. The half-period register cycles through 0, 1, 2 and 3 across the runs, and the transmit bytes and MISO stream are derived arithmetically from the count. This separates off-by-one errors at byte boundaries and at the 48-bit edge where MOSI must fall to zero. It also catches a receive bank that is justified to the wrong end, and a chip-select window that depends wrongly on H. Separate runs clamp a count of 60 to 56. Another run fires `start` and register writes in the middle of a command, then reruns without reloading to show that the old settings survived.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_HIGH,
      ST_LOW,
      ST_TAIL
   } eng_state_t;
endpackage

// File: rtl/spi_cmd_divider.sv
module spi_cmd_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == half - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run || tick)  cnt_q <= '0;
      else                    cnt_q <= cnt_q + DIV_W'(1);
   end
endmodule

// File: rtl/spi_cmd_txbank.sv
module spi_cmd_txbank
   import spi_cmd_pkg::*;
#(
   parameter int TX_BYTES = 6,
   parameter int ADDR_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              load,
   input  logic              shift,
   output logic              bit_out
);
   localparam int SH_W = BYTE_W * TX_BYTES;

   logic [SH_W-1:0] flat;
   logic [SH_W-1:0] sh_q;

   for (genvar g = 0; g < TX_BYTES; g++) begin : g_byte
      logic [BYTE_W-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    r_q <= '0;
         else if (wr_en && wr_addr == ADDR_W'(g))       r_q <= wr_data;
      end
      assign flat[BYTE_W*g +: BYTE_W] = r_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sh_q <= '0;
      else if (load)   sh_q <= flat;
      else if (shift)  sh_q <= {sh_q[SH_W-2:0], 1'b0};
   end

   assign bit_out = sh_q[SH_W-1];
endmodule

// File: rtl/spi_cmd_rxbank.sv
module spi_cmd_rxbank
   import spi_cmd_pkg::*;
#(
   parameter int RX_BYTES = 7,
   parameter int RD_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              sample,
   input  logic              miso,
   input  logic [RD_W-1:0]   rd_addr,
   output logic [BYTE_W-1:0] rd_data
);
   localparam int SH_W = BYTE_W * RX_BYTES;

   logic [SH_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sh_q <= '0;
      else if (clear)   sh_q <= '0;
      else if (sample)  sh_q <= {sh_q[SH_W-2:0], miso};
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < RX_BYTES; i++) begin
         if (rd_addr == RD_W'(i)) rd_data = sh_q[BYTE_W*i +: BYTE_W];
      end
   end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spi_cmd_pkg::*;
#(
   parameter  int TX_BYTES = 6,
   parameter  int DIV_W    = 8,
   localparam int RX_BYTES = TX_BYTES + 1,
   localparam int MAX_BITS = BYTE_W * RX_BYTES,
   localparam int CNT_W    = $clog2(MAX_BITS + 1),
   localparam int ADDR_W   = $clog2(TX_BYTES + 2),
   localparam int RD_W     = $clog2(RX_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [RD_W-1:0]   rd_addr,
   output logic [7:0]        rd_data,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              sck,
   output logic              cs_n,
   output logic              mosi,
   input  logic              miso
);
   if (TX_BYTES < 1 || TX_BYTES > 30) begin : g_bad_bytes
      $error("TX_BYTES must lie in 1..30");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   eng_state_t       state_q;
   logic [CNT_W-1:0] cnt_q, left_q;
   logic [DIV_W-1:0] div_q, half;
   logic             busy_q, done_q, sck_q, cs_n_q;
   logic             wr_ok, tick, load, shift, sample, tx_bit;

   assign wr_ok = wr_en && !busy_q;
   assign half  = (div_q == '0) ? DIV_W'(1) : div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         div_q <= '0;
      end else if (wr_ok) begin
         if (wr_addr == ADDR_W'(TX_BYTES))
            cnt_q <= (wr_data > 8'(MAX_BITS)) ? CNT_W'(MAX_BITS) : CNT_W'(wr_data);
         if (wr_addr == ADDR_W'(TX_BYTES + 1))
            div_q <= DIV_W'(wr_data);
      end
   end

   assign load   = (state_q == ST_IDLE) && start && (cnt_q != '0);
   assign shift  = tick && (state_q == ST_HIGH) && (left_q != CNT_W'(1));
   assign sample = tick && (state_q == ST_LEAD || state_q == ST_LOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         left_q  <= '0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         sck_q   <= 1'b0;
         cs_n_q  <= 1'b1;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start && cnt_q == '0) begin
                  done_q <= 1'b1;
               end else if (load) begin
                  busy_q  <= 1'b1;
                  cs_n_q  <= 1'b0;
                  left_q  <= cnt_q;
                  state_q <= ST_LEAD;
               end
            end
            ST_LEAD, ST_LOW: begin
               if (tick) begin
                  sck_q   <= 1'b1;
                  state_q <= ST_HIGH;
               end
            end
            ST_HIGH: begin
               if (tick) begin
                  sck_q   <= 1'b0;
                  left_q  <= left_q - CNT_W'(1);
                  state_q <= (left_q == CNT_W'(1)) ? ST_TAIL : ST_LOW;
               end
            end
            ST_TAIL: begin
               if (tick) begin
                  cs_n_q  <= 1'b1;
                  busy_q  <= 1'b0;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   spi_cmd_divider #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state_q != ST_IDLE),
      .half  (half),
      .tick  (tick)
   );

   spi_cmd_txbank #(.TX_BYTES(TX_BYTES), .ADDR_W(ADDR_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ok),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .load    (load),
      .shift   (shift),
      .bit_out (tx_bit)
   );

   spi_cmd_rxbank #(.RX_BYTES(RX_BYTES), .RD_W(RD_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (load),
      .sample  (sample),
      .miso    (miso),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   assign busy = busy_q;
   assign done = done_q;
   assign sck  = sck_q;
   assign cs_n = cs_n_q;
   assign mosi = tx_bit && !cs_n_q;
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
   parameter int CNT_W  = 6,
   parameter int DIV_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             sck,
   input logic             cs_n,
   input logic             mosi,
   input logic [CNT_W-1:0] cnt_q,
   input logic [DIV_W-1:0] div_q
);
   logic           sck_d;
   logic [CNT_W:0] rises;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         rises <= '0;
      end else begin
         sck_d <= sck;
         if (cs_n)               rises <= '0;
         else if (sck && !sck_d) rises <= rises + 1'b1;
      end
   end

   // R1: rising edges within one command never exceed the programmed count
   a_r1_edges_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> rises <= {1'b0, cnt_q});

   // R5: serial clock idles low outside chip select
   a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);

   // R6: data out held while the serial clock stays high
   a_r6_mosi_held_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && sck_d) |-> $stable(mosi));

   // R8: busy and chip select agree, done arrives as busy drops
   a_r8_busy_cs: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cs_n);
   a_r8_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done && cs_n));

   // R4: a start while busy keeps the command running
   a_r4_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !cs_n && !sck_d && sck) |=> busy);

   // R9: zero count finishes on the next edge without selecting the flash
   a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && cnt_q == '0) |=> (done && cs_n && !busy));

   // R10: configuration registers are frozen while busy
   a_r10_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(cnt_q) && $stable(div_q)));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .busy  (busy),
   .done  (done),
   .sck   (sck),
   .cs_n  (cs_n),
   .mosi  (mosi),
   .cnt_q (cnt_q),
   .div_q (div_q)
);

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       start = 1'b0;
   logic       busy, done, sck, cs_n, mosi;
   logic       miso = 1'b0;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   spi_cmd_engine u_spi_cmd_engine (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .start(start), .busy(busy), .done(done), .sck(sck),
      .cs_n(cs_n), .mosi(mosi), .miso(miso)
   );

   logic [7:0]  tx_b [6];
   logic [55:0] pat = '0;
   logic [55:0] cap = '0;
   int mi_idx = 0;
   int rises = 0, cs_cycles = 0, lead_cycles = 0, busy_cycles = 0;
   int done_cnt = 0, hi_changes = 0;
   logic prev_sck = 1'b0, prev_mosi = 1'b0;

   // flash model: drives MISO on chip select fall and each falling SCK
   always @(negedge cs_n) begin
      mi_idx = 0;
      miso = pat[55];
   end
   always @(negedge sck) if (!cs_n) begin
      mi_idx++;
      miso = (mi_idx < 56) ? pat[55 - mi_idx] : 1'b0;
   end
   always @(posedge sck) begin
      cap = {cap[54:0], mosi};
      rises++;
   end
   always @(negedge clk) begin
      if (!cs_n) cs_cycles++;
      if (!cs_n && rises == 0) lead_cycles++;
      if (busy) busy_cycles++;
      if (done) done_cnt++;
      if (sck && prev_sck && mosi != prev_mosi) hi_changes++;
      prev_sck = sck;
      prev_mosi = mosi;
   end

   task automatic chk(bit ok, string tag, string what, longint act, longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_data(int n);
      for (int i = 0; i < 6; i++) tx_b[i] = 8'(n * 37 + i * 71 + 5);
      pat = 56'hA5C30F961E2D7B ^ {7{8'(n * 29 + 3)}};
   endtask

   task automatic load_regs(int n, int dv);
      for (int i = 0; i < 6; i++) wr(i, int'(tx_b[i]));
      wr(6, n);
      wr(7, dv);
   endtask

   task automatic fire();
      @(negedge clk);
      cap = '0; rises = 0; cs_cycles = 0; lead_cycles = 0;
      busy_cycles = 0; done_cnt = 0; hi_changes = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic check_run(int n, int h, string tag);
      logic [55:0] txcat, exp_tx, exp_rx, mask, rx_all;
      if (n == 0) begin
         chk(rises == 0, "R9", {tag, " sck edges"}, rises, 0);
         chk(cs_cycles == 0 && busy_cycles == 0, "R9", {tag, " cs/busy cycles"},
             cs_cycles + busy_cycles, 0);
         chk(done_cnt == 1, "R9", {tag, " done pulses"}, done_cnt, 1);
         return;
      end
      txcat  = {tx_b[5], tx_b[4], tx_b[3], tx_b[2], tx_b[1], tx_b[0], 8'h00};
      mask   = (n == 56) ? '1 : ((56'd1 << n) - 56'd1);
      exp_tx = txcat >> (56 - n);
      exp_rx = pat >> (56 - n);
      chk(rises == n, "R1", {tag, " sck edges"}, rises, n);
      chk((cap & mask) == exp_tx, "R2", {tag, " mosi bits"}, longint'(cap & mask), longint'(exp_tx));
      for (int i = 0; i < 7; i++) begin
         rd_addr = 3'(i);
         #1;
         rx_all[8*i +: 8] = rd_data;
      end
      chk(rx_all == exp_rx, "R3", {tag, " rx bank"}, longint'(rx_all), longint'(exp_rx));
      chk(cs_cycles == (2 * n + 1) * h, "R5 R7", {tag, " cs low cycles"}, cs_cycles, (2 * n + 1) * h);
      chk(lead_cycles == h, "R5 R7", {tag, " lead cycles"}, lead_cycles, h);
      chk(hi_changes == 0, "R6", {tag, " mosi change with sck high"}, hi_changes, 0);
      chk(busy_cycles == (2 * n + 1) * h && done_cnt == 1, "R8", {tag, " busy/done"},
          busy_cycles * 16 + done_cnt, (2 * n + 1) * h * 16 + 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R5 R8: reset state
      chk(cs_n == 1'b1 && sck == 1'b0, "R5", "reset cs_n/sck", {cs_n, sck}, 2'b10);
      chk(busy == 1'b0 && done == 1'b0, "R8", "reset busy/done", {busy, done}, 0);
      chk(rd_data == 8'h00, "R3", "reset rx byte", rd_data, 0);

      // sweep every bit count, half-period register 0..3
      for (int n = 0; n <= 56; n++) begin
         int dv = n % 4;
         int h = (dv == 0) ? 1 : dv;
         set_data(n);
         load_regs(n, dv);
         fire();
         repeat ((2 * n + 2) * h + 6) @(negedge clk);
         check_run(n, h, $sformatf("n=%0d h=%0d", n, h));
      end

      // R1: count above the limit clamps to 56
      set_data(60);
      load_regs(60, 1);
      fire();
      repeat (130) @(negedge clk);
      check_run(56, 1, "R1 clamp 60");

      // R4 R10: start and writes during a command
      set_data(16);
      load_regs(16, 2);
      fire();
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wr(6, 8);
      wr(5, 8'hFF);
      wr(7, 5);
      repeat (80) @(negedge clk);
      chk(rises == 16, "R4", "edges with mid-run start", rises, 16);
      chk(cs_cycles == 66 && done_cnt == 1, "R4", "cs cycles/done with mid-run start",
          cs_cycles * 16 + done_cnt, 66 * 16 + 1);
      fire();
      repeat (80) @(negedge clk);
      check_run(16, 2, "R10 rerun after busy writes");

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule